// File: doc/BRIEF.md
# Pulse-Pause Bit Encoder

This block is the transmit side of a reader-to-card contactless link that signals each bit by the length of a symbol rather than by a level. Each symbol starts by switching the carrier off for a fixed pause. The carrier then comes back on, and it stays on until the symbol has run for a long total period (logical 1) or a short one (logical 0). Before encoding, each payload bit is XORed with one bit from an external keystream source. The block asks for the next keystream bit with a one-cycle advance strobe, sent once per transmitted bit.

A frame is launched with a single-cycle start pulse together with a payload word and a bit count. Bits are shifted out least significant first. After the last symbol the block sends one more carrier-off pause and then leaves the carrier on to close the frame. All durations are counted in pulses of a tick enable input, so the clock frequency and the timing resolution are independent of each other. When the frame ends, the block restarts its tick counter and exposes it, so that a receiver can measure the delay to the card's reply from that moment.

Top module: `pp_encoder`

## Requirements
- R1: After reset and between frames, carrier_en is 1, busy is 0, and ks_step and done are 0.
- R2: Each transmitted symbol begins with carrier_en at 0 for PAUSE_TICKS tick pulses (default 30).
- R3: Counting from the start of its pause, a symbol lasts ONE_TICKS tick pulses (default 150) for symbol value 1 and ZERO_TICKS (default 90) for symbol value 0. After the pause, carrier_en is 1 for the rest of the symbol.
- R4: Payload bits go out least significant bit first. Symbol i equals data_in[i] XOR the value of ks_bit sampled when that symbol's pause begins.
- R5: ks_step is high for exactly one cycle per symbol: the first cycle in which carrier_en has returned to 1 within that symbol. A frame of n bits therefore produces exactly n strobes.
- R6: After the last symbol, carrier_en is 0 for PAUSE_TICKS more tick pulses and then returns to 1. In that same cycle, done pulses high for one cycle and busy falls.
- R7: The bit count is sampled at start. A count of 0 is sent as a 1-bit frame, and a count above DATA_W is sent as DATA_W bits.
- R8: A start pulse received while busy is 1 is ignored, and the running frame continues unchanged.
- R9: reply_ticks is 0 while busy and 0 in the done cycle. After that it rises by one per tick pulse and saturates at its maximum.
- R10: Every duration is counted only on cycles with tick_en high. Cycles without a tick do not advance any phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Timing resolution enable, one pulse per tick |
| start | input | 1 | Single-cycle frame launch |
| data_in | input | DATA_W | Payload word, bit 0 sent first |
| nbits_in | input | $clog2(DATA_W+1) | Number of bits to send |
| ks_bit | input | 1 | Current keystream bit |
| ks_step | output | 1 | Keystream advance strobe |
| carrier_en | output | 1 | Carrier enable, 0 during pauses |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle pulse at frame end |
| reply_ticks | output | CNT_W | Ticks elapsed since the last frame ended |

## Verification
The bench uses the default parameters: a 32-bit payload, 30/150/90-tick timing and a 16-bit counter. The full-width payload makes 32-bit all-ones and all-zeros frames possible, and the 6-bit count input can carry values above 32, so the clamp can be reached. An 8-bit LFSR in the bench supplies the keystream and moves only on ks_step, so the whitened symbol pattern differs from the raw data. Most frames run with a tick on every cycle, which makes the carrier run lengths equal to tick counts. One frame uses a tick every third cycle to show that timing scales with tick_en.

// File: rtl/pp_pkg.sv
package pp_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_PAUSE = 2'd1,
    ST_MARK  = 2'd2,
    ST_TAIL  = 2'd3
  } pp_state_t;
endpackage

// File: rtl/pp_tick_timer.sv
module pp_tick_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             clr,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt;
    if (clr)
      cnt_d = '0;
    else if (tick && (cnt != CNT_MAX))
      cnt_d = cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_d;
  end

  // R10
  no_tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !clr) |=> $stable(cnt));

  // R9
  sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((cnt == CNT_MAX) && !clr) |=> (cnt == CNT_MAX));
endmodule

// File: rtl/pp_bit_shifter.sv
module pp_bit_shifter #(
  parameter int DATA_W = 32,
  parameter int NB_W   = $clog2(DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              shift,
  input  logic [DATA_W-1:0] data_in,
  input  logic [NB_W-1:0]   nbits_in,
  output logic              cur_bit,
  output logic              last_bit
);
  localparam logic [NB_W-1:0] NB_MAX = NB_W'(DATA_W);
  localparam logic [NB_W-1:0] NB_ONE = NB_W'(1);

  logic [DATA_W-1:0] sreg_q, sreg_d;
  logic [NB_W-1:0]   left_q, left_d;
  logic [NB_W-1:0]   n_clamped;

  always_comb begin
    if (nbits_in == '0)
      n_clamped = NB_ONE;
    else if (nbits_in > NB_MAX)
      n_clamped = NB_MAX;
    else
      n_clamped = nbits_in;
  end

  always_comb begin
    sreg_d = sreg_q;
    left_d = left_q;
    if (load) begin
      sreg_d = data_in;
      left_d = n_clamped;
    end else if (shift) begin
      sreg_d = {1'b0, sreg_q[DATA_W-1:1]};
      if (left_q != '0) left_d = left_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg_q <= '0;
      left_q <= '0;
    end else begin
      sreg_q <= sreg_d;
      left_q <= left_d;
    end
  end

  assign cur_bit  = sreg_q[0];
  assign last_bit = (left_q == NB_ONE);

  // R7
  count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> ((left_q != '0) && (left_q <= NB_MAX)));
endmodule

// File: rtl/pp_seq.sv
module pp_seq
  import pp_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int PAUSE_TICKS = 30,
  parameter int ONE_TICKS   = 150,
  parameter int ZERO_TICKS  = 90
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             start,
  input  logic [CNT_W-1:0] cnt,
  input  logic             cur_bit,
  input  logic             last_bit,
  input  logic             ks_bit,
  output logic             load,
  output logic             shift,
  output logic             clr,
  output logic             carrier_en,
  output logic             busy,
  output logic             done,
  output logic             ks_step
);
  localparam logic [CNT_W-1:0] PAUSE_LAST = CNT_W'(PAUSE_TICKS - 1);
  localparam logic [CNT_W-1:0] ONE_LAST   = CNT_W'(ONE_TICKS - PAUSE_TICKS - 1);
  localparam logic [CNT_W-1:0] ZERO_LAST  = CNT_W'(ZERO_TICKS - PAUSE_TICKS - 1);

  pp_state_t        state_q, state_d;
  logic             ks_q, ks_d;
  logic             done_q, done_d;
  logic             step_q, step_d;
  logic             sym;
  logic [CNT_W-1:0] phase_last;
  logic             phase_end;

  assign sym = cur_bit ^ ks_q;

  always_comb begin
    case (state_q)
      ST_MARK: phase_last = sym ? ONE_LAST : ZERO_LAST;
      default: phase_last = PAUSE_LAST;
    endcase
  end

  assign phase_end = tick && (cnt == phase_last);

  always_comb begin
    state_d = state_q;
    ks_d    = ks_q;
    load    = 1'b0;
    shift   = 1'b0;
    clr     = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start) begin
          load    = 1'b1;
          clr     = 1'b1;
          ks_d    = ks_bit;
          state_d = ST_PAUSE;
        end
      end
      ST_PAUSE: begin
        if (phase_end) begin
          clr     = 1'b1;
          state_d = ST_MARK;
        end
      end
      ST_MARK: begin
        if (phase_end) begin
          clr   = 1'b1;
          shift = 1'b1;
          if (last_bit) begin
            state_d = ST_TAIL;
          end else begin
            ks_d    = ks_bit;
            state_d = ST_PAUSE;
          end
        end
      end
      ST_TAIL: begin
        if (phase_end) begin
          clr     = 1'b1;
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign step_d = (state_q == ST_PAUSE) && phase_end;
  assign done_d = (state_q == ST_TAIL) && phase_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ks_q    <= 1'b0;
      done_q  <= 1'b0;
      step_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      ks_q    <= ks_d;
      done_q  <= done_d;
      step_q  <= step_d;
    end
  end

  assign carrier_en = (state_q == ST_IDLE) || (state_q == ST_MARK);
  assign busy       = (state_q != ST_IDLE);
  assign done       = done_q;
  assign ks_step    = step_q;

  // R6
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R6
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (carrier_en && !busy));

  // R5
  step_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ks_step |=> !ks_step);

  // R5
  step_in_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ks_step |-> (carrier_en && busy));
endmodule

// File: rtl/pp_encoder.sv
module pp_encoder #(
  parameter int DATA_W      = 32,
  parameter int CNT_W       = 16,
  parameter int PAUSE_TICKS = 30,
  parameter int ONE_TICKS   = 150,
  parameter int ZERO_TICKS  = 90,
  localparam int NB_W       = $clog2(DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              start,
  input  logic [DATA_W-1:0] data_in,
  input  logic [NB_W-1:0]   nbits_in,
  input  logic              ks_bit,
  output logic              ks_step,
  output logic              carrier_en,
  output logic              busy,
  output logic              done,
  output logic [CNT_W-1:0]  reply_ticks
);
  logic [CNT_W-1:0] cnt;
  logic             load, shift, clr;
  logic             cur_bit, last_bit;

  pp_tick_timer #(.CNT_W(CNT_W)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick_en),
    .clr   (clr),
    .cnt   (cnt)
  );

  pp_bit_shifter #(.DATA_W(DATA_W), .NB_W(NB_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .shift    (shift),
    .data_in  (data_in),
    .nbits_in (nbits_in),
    .cur_bit  (cur_bit),
    .last_bit (last_bit)
  );

  pp_seq #(
    .CNT_W       (CNT_W),
    .PAUSE_TICKS (PAUSE_TICKS),
    .ONE_TICKS   (ONE_TICKS),
    .ZERO_TICKS  (ZERO_TICKS)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick_en),
    .start      (start),
    .cnt        (cnt),
    .cur_bit    (cur_bit),
    .last_bit   (last_bit),
    .ks_bit     (ks_bit),
    .load       (load),
    .shift      (shift),
    .clr        (clr),
    .carrier_en (carrier_en),
    .busy       (busy),
    .done       (done),
    .ks_step    (ks_step)
  );

  assign reply_ticks = busy ? '0 : cnt;

  // R9
  reply_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (reply_ticks == '0));
endmodule

// File: tb/sim_pp_encoder.sv
module sim_pp_encoder;
  localparam int DATA_W = 32;
  localparam int CNT_W  = 16;
  localparam int NB_W   = $clog2(DATA_W + 1);

  logic              clk;
  logic              rst_n;
  logic              tick_en;
  logic              start;
  logic [DATA_W-1:0] data_in;
  logic [NB_W-1:0]   nbits_in;
  logic              ks_bit;
  logic              ks_step;
  logic              carrier_en;
  logic              busy;
  logic              done;
  logic [CNT_W-1:0]  reply_ticks;

  int   total = 0;
  int   bad   = 0;
  int   tick_mult = 1;
  int   tick_ph   = 0;
  int   cycles    = 0;
  logic [7:0] lfsr;

  pp_encoder #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u0 (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .start(start),
    .data_in(data_in), .nbits_in(nbits_in), .ks_bit(ks_bit),
    .ks_step(ks_step), .carrier_en(carrier_en), .busy(busy),
    .done(done), .reply_ticks(reply_ticks)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [7:0] lfsr_adv(input logic [7:0] s);
    return {s[6:0], s[7] ^ s[5] ^ s[4] ^ s[3]};
  endfunction

  assign ks_bit = lfsr[0];
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n)       lfsr <= 8'hA5;
    else if (ks_step) lfsr <= lfsr_adv(lfsr);
  end

  always @(negedge clk) begin
    if (tick_ph + 1 >= tick_mult) begin
      tick_ph = 0;
      tick_en = 1'b1;
    end else begin
      tick_ph = tick_ph + 1;
      tick_en = 1'b0;
    end
  end

  task automatic report;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles = cycles + 1;
    if (cycles > 150000) begin
      total = total + 1;
      bad = bad + 1;
      $display("FAIL watchdog: actual=%0d cycles expected=<150000", cycles);
      report();
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total = total + 1;
    if (!ok) begin
      bad = bad + 1;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Send one frame and check run lengths, strobes and the frame end.
  task automatic run_frame(input logic [DATA_W-1:0] d, input int nb_in, input int n_eff,
                           input int glitch_at, input string name);
    logic [7:0] ks_s;
    logic exp_sym [DATA_W];
    int runs [2*DATA_W+2];
    int nruns, cur_len, steps, cyc, step_bad;
    logic cur_lvl, prev_c;
    bit seen_done, busy_zero_seen;
    ks_s = lfsr;
    for (int i = 0; i < DATA_W; i++) begin
      exp_sym[i] = (i < n_eff) ? (d[i] ^ ks_s[0]) : 1'b0;
      if (i < n_eff) ks_s = lfsr_adv(ks_s);
    end
    @(negedge clk);
    start = 1'b1; data_in = d; nbits_in = NB_W'(nb_in);
    @(negedge clk);
    start = 1'b0; data_in = ~d; nbits_in = NB_W'(3);
    nruns = 0; cur_len = 1; cur_lvl = carrier_en; prev_c = carrier_en;
    steps = 0; step_bad = 0; seen_done = 0; busy_zero_seen = 1; cyc = 0;
    while (!seen_done && cyc < 40000) begin
      @(negedge clk);
      cyc = cyc + 1;
      start = (cyc == glitch_at);
      if (ks_step) begin
        steps = steps + 1;
        if (!(carrier_en && !prev_c)) step_bad = step_bad + 1;
      end
      if (busy && reply_ticks != 0) busy_zero_seen = 0;
      if (done) begin
        seen_done = 1;
        if (nruns < 2*DATA_W+2) runs[nruns] = cur_len;
        nruns = nruns + 1;
      end else if (carrier_en == cur_lvl) begin
        cur_len = cur_len + 1;
      end else begin
        if (nruns < 2*DATA_W+2) runs[nruns] = cur_len;
        nruns = nruns + 1;
        cur_len = 1;
        cur_lvl = carrier_en;
      end
      prev_c = carrier_en;
    end
    start = 1'b0;
    chk(seen_done, {name, " R6 frame ends with done"}, seen_done, 1);
    chk(done && !busy && carrier_en, {name, " R6 idle at done"}, {busy, carrier_en}, 1);
    chk(reply_ticks == 0, {name, " R9 reply zero at done"}, reply_ticks, 0);
    chk(busy_zero_seen, {name, " R9 reply zero while busy"}, busy_zero_seen, 1);
    chk(nruns == 2*n_eff + 1, {name, " R7 R8 run count"}, nruns, 2*n_eff + 1);
    chk(steps == n_eff, {name, " R5 strobe count"}, steps, n_eff);
    chk(step_bad == 0, {name, " R5 strobe placement"}, step_bad, 0);
    if (nruns == 2*n_eff + 1) begin
      for (int i = 0; i < n_eff; i++) begin
        int lo_exp, hi_exp;
        lo_exp = 30 * tick_mult;
        hi_exp = (exp_sym[i] ? 120 : 60) * tick_mult;
        if (i == 0 && tick_mult > 1)
          chk(runs[0] <= lo_exp && runs[0] >= lo_exp - tick_mult + 1,
              {name, " R2 R10 first pause"}, runs[0], lo_exp);
        else
          chk(runs[2*i] == lo_exp, {name, " R2 pause length"}, runs[2*i], lo_exp);
        chk(runs[2*i+1] == hi_exp, {name, " R3 R4 carrier-on length"}, runs[2*i+1], hi_exp);
      end
      chk(runs[2*n_eff] == 30 * tick_mult, {name, " R6 tail pause"}, runs[2*n_eff], 30 * tick_mult);
    end
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(carrier_en == 1'b1, "R1 carrier after reset", carrier_en, 1);
    chk(busy == 1'b0, "R1 busy after reset", busy, 0);
    chk(done == 1'b0 && ks_step == 1'b0, "R1 strobes after reset", {done, ks_step}, 0);
  endtask

  task automatic t_mixed;
    run_frame(32'h0000_002D, 6, 6, 0, "mixed6");
    run_frame(32'hC3A5_5A3C, 32, 32, 0, "mixed32");
  endtask

  task automatic t_extremes;
    run_frame(32'hFFFF_FFFF, 32, 32, 0, "ones32");
    run_frame(32'h0000_0000, 32, 32, 0, "zeros32");
  endtask

  task automatic t_clamp;
    run_frame(32'h0000_0001, 0, 1, 0, "r7_zero_count");
    run_frame(32'h1234_5678, 40, 32, 0, "r7_over_count");
  endtask

  task automatic t_ignore_start;
    run_frame(32'h0000_0B6E, 12, 12, 200, "r8_start_busy");
  endtask

  task automatic t_reply;
    run_frame(32'h0000_0055, 7, 7, 0, "r9_frame");
    repeat (5) @(negedge clk);
    chk(reply_ticks == 5, "R9 reply count after 5 ticks", reply_ticks, 5);
    chk(carrier_en == 1'b1 && busy == 1'b0, "R1 idle between frames", {carrier_en, busy}, 2);
  endtask

  task automatic t_slow_tick;
    tick_mult = 3;
    run_frame(32'h0000_0396, 10, 10, 0, "r10_tick3");
    tick_mult = 1;
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; data_in = '0; nbits_in = '0; tick_en = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_mixed();
    t_extremes();
    t_clamp();
    t_ignore_start();
    t_reply();
    t_slow_tick();
    report();
  end
endmodule